// File: doc/BRIEF.md
# Byte-Lane Organization Adapter for a 32-bit SRAM

This block sits between a host-side memory request and a 32-bit asynchronous SRAM that has one active-low chip enable per byte lane. It lets the same array be used as 128K words of 32 bits, 256K halfwords of 16 bits or 512K bytes of 8 bits. A two-bit organization input picks the view. In the narrow views, the lowest host address bits choose which byte enables are driven low. The remaining bits form the 17-bit word address. Narrow write data is copied onto every lane, so only the enabled lanes store it. Narrow read data is taken from the selected lane and placed in the low bits of the host read bus.

The adapter is purely combinational. Every output follows its inputs in the same cycle, and the block holds no state. The write and read strobe timing belongs to a sequencer upstream, and the tristate pads belong to the pad ring. The request side is a single qualifier, `req_valid`. The block has no back-pressure: it accepts every request it sees, and flow control belongs to the sequencer that drives it. When `req_valid` is low, all four enables and both strobes stay high, which puts the whole device in standby.

Top module: `sram_lane_adapter`

## Requirements
- R1: With `req_valid` low, `sram_ce_n` is 4'b1111 and both `sram_we_n` and `sram_oe_n` are 1, in every organization.
- R2: Organization 2'b00 (x32): with `req_valid` high, all four enables are 0. `sram_addr` equals `host_addr[16:0]`, `sram_wdata` equals `host_wdata`, and `host_rdata` equals `sram_rdata`.
- R3: Organization 2'b01 (x16): with `req_valid` high, `host_addr[0]`=0 gives `sram_ce_n`=4'b1100 (lanes 0 and 1 enabled). `host_addr[0]`=1 gives 4'b0011 (lanes 2 and 3 enabled). `sram_addr` equals `host_addr[17:1]`.
- R4: Organization 2'b10 (x8): with `req_valid` high, exactly one bit of `sram_ce_n` is 0, the one at index `host_addr[1:0]`. `sram_addr` equals `host_addr[18:2]`.
- R5: Write data is replicated onto the lanes. In x16, `sram_wdata` is `{host_wdata[15:0], host_wdata[15:0]}`. In x8, it is `host_wdata[7:0]` repeated four times.
- R6: x16 read: `host_rdata` is `sram_rdata[15:0]` when `host_addr[0]`=0 and `sram_rdata[31:16]` when it is 1. In both cases bits 31:16 of `host_rdata` are zero.
- R7: x8 read: `host_rdata[7:0]` is byte lane `host_addr[1:0]` of `sram_rdata`, and bits 31:8 of `host_rdata` are zero.
- R8: Organization 2'b11 is reserved and treated as idle. All enables and strobes are 1, and `sram_addr`, `sram_wdata` and `host_rdata` are all zero.
- R9: `sram_we_n` is 0 exactly when `req_valid` and `req_write` are 1 and the organization is not reserved. `sram_oe_n` is 0 exactly when `req_valid` is 1, `req_write` is 0 and the organization is not reserved. The two strobes are never both 0.
- R10: Host address bits above the current view's width have no effect. Bits 18:17 are ignored in x32, and bit 18 is ignored in x16.
- R11: The address, write-data and read-data mapping of R2 to R7 applies whether `req_valid` is high or low. Only the enables and strobes are qualified by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| org_mode | input | 2 | Organization: 00 x32, 01 x16, 10 x8, 11 reserved |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Host address in units of the current view |
| host_wdata | input | 32 | Host write data, low bits used in narrow views |
| host_rdata | output | 32 | Host read data, zero-extended in narrow views |
| sram_addr | output | 17 | Word address to the array |
| sram_ce_n | output | 4 | Active-low chip enable per byte lane |
| sram_we_n | output | 1 | Active-low master write strobe |
| sram_oe_n | output | 1 | Active-low master output enable |
| sram_wdata | output | 32 | Data driven toward the lanes |
| sram_rdata | input | 32 | Data returned from the lanes |

## Verification
The case hardest to reach is a mismatch that only a particular combination shows: a narrow view with an upper lane selected, garbage in the ignored high address bits, and read data whose lanes all differ. A lane-swap or off-by-one error can hide when any of these is missing. The stimulus starts with directed sweeps of every organization against every low-address value. It uses distinct byte patterns per lane and sets the unused address bits to ones. It then runs a long random phase that also covers idle and reserved-mode cycles. The bench model is compared against every output on every cycle.

// File: rtl/lane_adapt_pkg.sv
package lane_adapt_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_AW = 17;

  typedef enum logic [1:0] {
    ORG_X32  = 2'b00,
    ORG_X16  = 2'b01,
    ORG_X8   = 2'b10,
    ORG_RSVD = 2'b11
  } org_e;
endpackage

// File: rtl/sla_lane_decode.sv
module sla_lane_decode
  import lane_adapt_pkg::*;
#(
  parameter int NLANE = LANES,
  localparam int SELW = $clog2(NLANE),
  localparam int HALF = NLANE / 2
) (
  input  org_e             org,
  input  logic             valid,
  input  logic [SELW-1:0]  sel,
  output logic [NLANE-1:0] ce_n
);
  logic [NLANE-1:0] en;

  always_comb begin
    en = '0;
    if (valid) begin
      unique case (org)
        ORG_X32: en = '1;
        ORG_X16: begin
          for (int i = 0; i < NLANE; i++)
            en[i] = ((i / HALF) == int'(sel[0]));
        end
        ORG_X8: begin
          for (int i = 0; i < NLANE; i++)
            en[i] = (sel == SELW'(i));
        end
        default: en = '0;
      endcase
    end
  end

  assign ce_n = ~en;

  // R4: a valid byte access opens exactly one lane
  always_comb begin
    if (valid && org == ORG_X8)
      assert_single_lane_R4: assert ($countones(~ce_n) == 1);
    if (valid && org == ORG_X16)
      assert_half_lanes_R3: assert ($countones(~ce_n) == HALF);
  end
endmodule

// File: rtl/sla_addr_map.sv
module sla_addr_map
  import lane_adapt_pkg::*;
#(
  parameter int AW    = WORD_AW,
  parameter int NLANE = LANES,
  localparam int SELW = $clog2(NLANE),
  localparam int HAW  = AW + SELW
) (
  input  org_e           org,
  input  logic [HAW-1:0] host_addr,
  output logic [AW-1:0]  word_addr
);
  always_comb begin
    unique case (org)
      ORG_X32: word_addr = host_addr[AW-1:0];
      ORG_X16: word_addr = host_addr[AW:1];
      ORG_X8:  word_addr = host_addr[HAW-1:SELW];
      default: word_addr = '0;
    endcase
  end
endmodule

// File: rtl/sla_wdata_fanout.sv
module sla_wdata_fanout
  import lane_adapt_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int LW    = LANE_W,
  localparam int DW   = NLANE * LW,
  localparam int HALF = NLANE / 2
) (
  input  org_e          org,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] lane_wdata
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_comb begin
      unique case (org)
        ORG_X32: lane_wdata[g*LW +: LW] = host_wdata[g*LW +: LW];
        ORG_X16: lane_wdata[g*LW +: LW] = host_wdata[(g % HALF)*LW +: LW];
        ORG_X8:  lane_wdata[g*LW +: LW] = host_wdata[0 +: LW];
        default: lane_wdata[g*LW +: LW] = '0;
      endcase
    end
  end

  // R5: both halves carry the same halfword in the 16-bit view
  always_comb begin
    if (org == ORG_X16)
      assert_halves_match_R5: assert (lane_wdata[DW-1:DW/2] == lane_wdata[DW/2-1:0]);
  end
endmodule

// File: rtl/sla_rdata_steer.sv
module sla_rdata_steer
  import lane_adapt_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int LW    = LANE_W,
  localparam int DW   = NLANE * LW,
  localparam int SELW = $clog2(NLANE),
  localparam int HW   = DW / 2
) (
  input  org_e            org,
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   lane_rdata,
  output logic [DW-1:0]   host_rdata
);
  logic [HW-1:0] half_pick;
  logic [LW-1:0] byte_pick;

  always_comb begin
    half_pick = lane_rdata[int'(sel[0])*HW +: HW];
    byte_pick = '0;
    for (int i = 0; i < NLANE; i++)
      if (sel == SELW'(i)) byte_pick = lane_rdata[i*LW +: LW];
  end

  always_comb begin
    unique case (org)
      ORG_X32: host_rdata = lane_rdata;
      ORG_X16: host_rdata = {{(DW-HW){1'b0}}, half_pick};
      ORG_X8:  host_rdata = {{(DW-LW){1'b0}}, byte_pick};
      default: host_rdata = '0;
    endcase
  end

  // R7: byte view returns nothing above the selected lane
  always_comb begin
    if (org == ORG_X8)
      assert_byte_zero_ext_R7: assert (host_rdata[DW-1:LW] == '0);
    if (org == ORG_X16)
      assert_half_zero_ext_R6: assert (host_rdata[DW-1:HW] == '0);
  end
endmodule

// File: rtl/sram_lane_adapter.sv
module sram_lane_adapter
  import lane_adapt_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int LW    = LANE_W,
  parameter int AW    = WORD_AW,
  localparam int DW   = NLANE * LW,
  localparam int SELW = $clog2(NLANE),
  localparam int HAW  = AW + SELW
) (
  input  logic [1:0]       org_mode,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [HAW-1:0]   host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic [AW-1:0]    sram_addr,
  output logic [NLANE-1:0] sram_ce_n,
  output logic             sram_we_n,
  output logic             sram_oe_n,
  output logic [DW-1:0]    sram_wdata,
  input  logic [DW-1:0]    sram_rdata
);
  org_e            org;
  logic            legal;
  logic            live;
  logic [SELW-1:0] sel;

  assign org   = org_e'(org_mode);
  assign legal = (org != ORG_RSVD);
  assign live  = req_valid && legal;
  assign sel   = host_addr[SELW-1:0];

  sla_lane_decode #(.NLANE(NLANE)) u_dec (
    .org   (org),
    .valid (live),
    .sel   (sel),
    .ce_n  (sram_ce_n)
  );

  sla_addr_map #(.AW(AW), .NLANE(NLANE)) u_amap (
    .org       (org),
    .host_addr (host_addr),
    .word_addr (sram_addr)
  );

  sla_wdata_fanout #(.NLANE(NLANE), .LW(LW)) u_wfan (
    .org        (org),
    .host_wdata (host_wdata),
    .lane_wdata (sram_wdata)
  );

  sla_rdata_steer #(.NLANE(NLANE), .LW(LW)) u_rsteer (
    .org        (org),
    .sel        (sel),
    .lane_rdata (sram_rdata),
    .host_rdata (host_rdata)
  );

  assign sram_we_n = !(live && req_write);
  assign sram_oe_n = !(live && !req_write);

  always_comb begin
    assert_strobe_exclusive_R9: assert (sram_we_n || sram_oe_n);
    if (!req_valid)
      assert_idle_standby_R1: assert (&sram_ce_n);
    if (org == ORG_RSVD)
      assert_reserved_quiet_R8: assert ((&sram_ce_n) && sram_wdata == '0 && sram_addr == '0);
  end
endmodule

// File: tb/sram_lane_adapter_test.sv
module sram_lane_adapter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [1:0]  org_mode = 2'b11;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [16:0] sram_addr;
  logic [3:0]  sram_ce_n;
  logic        sram_we_n;
  logic        sram_oe_n;
  logic [31:0] sram_wdata;
  logic [31:0] sram_rdata = '0;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_adapter uut (
    .org_mode(org_mode), .req_valid(req_valid), .req_write(req_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: compute all outputs from the requirements.
  task automatic compare_all();
    int mode = int'(org_mode);
    int a    = int'(host_addr);
    int lo2  = a % 4;
    int lo1  = a % 2;
    int e_ce, e_we, e_oe;
    logic [31:0] e_addr, e_wd, e_rd;
    string tag;
    e_ce = 15; e_we = 1; e_oe = 1;
    e_addr = 0; e_wd = 0; e_rd = 0;
    case (mode)
      0: begin tag = "R2"; e_addr = a % (1 << 17);
         e_wd = host_wdata; e_rd = sram_rdata;
         if (req_valid) e_ce = 0; end
      1: begin tag = "R3"; e_addr = (a / 2) % (1 << 17);
         e_wd = {host_wdata[15:0], host_wdata[15:0]};
         e_rd = (sram_rdata >> (16 * lo1)) & 32'hFFFF;
         if (req_valid) e_ce = (lo1 == 0) ? 12 : 3; end
      2: begin tag = "R4"; e_addr = a / 4;
         e_wd = {4{host_wdata[7:0]}};
         e_rd = (sram_rdata >> (8 * lo2)) & 32'hFF;
         if (req_valid) e_ce = 15 - (1 << lo2); end
      default: tag = "R8";
    endcase
    if (mode != 3 && req_valid) begin
      e_we = req_write ? 0 : 1;
      e_oe = req_write ? 1 : 0;
    end
    if (!req_valid) tag = {tag, "/R1/R11"};
    chk(tag, "ce_n", 32'(sram_ce_n), 32'(e_ce));
    chk({tag, "/R10"}, "addr", 32'(sram_addr), e_addr);
    chk(mode == 3 ? "R8" : "R5", "wdata", sram_wdata, e_wd);
    chk(mode == 1 ? "R6" : (mode == 2 ? "R7" : tag), "rdata", host_rdata, e_rd);
    chk("R9", "we_n", 32'(sram_we_n), 32'(e_we));
    chk("R9", "oe_n", 32'(sram_oe_n), 32'(e_oe));
  endtask

  task automatic apply(input logic [1:0] m, input logic v, input logic w,
                       input logic [18:0] a, input logic [31:0] wd,
                       input logic [31:0] rd);
    @(negedge clk);
    org_mode = m; req_valid = v; req_write = w;
    host_addr = a; host_wdata = wd; sram_rdata = rd;
    #(CLK_PERIOD/4);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // reset-like idle state (R1, R8)
    apply(2'b11, 1'b0, 1'b0, '0, '0, '0);
    // directed sweep: every view against every low address value,
    // unused high address bits forced to ones (R10), distinct lanes
    for (int m = 0; m < 4; m++)
      for (int lo = 0; lo < 4; lo++)
        for (int rw = 0; rw < 2; rw++) begin
          apply(m[1:0], 1'b1, rw[0], {17'h1ABCD, lo[1:0]} | 19'h60000,
                32'hA1B2C3D4, 32'h44332211);
          apply(m[1:0], 1'b0, rw[0], {17'h00F0F, lo[1:0]},
                32'h5566_7788, 32'hDDCCBBAA);
        end
    // R10 explicit: high bits differ, mapped address must not
    apply(2'b00, 1'b1, 1'b0, 19'h7FFFF, 32'h0, 32'h0);
    apply(2'b00, 1'b1, 1'b0, 19'h1FFFF, 32'h0, 32'h0);
    apply(2'b01, 1'b1, 1'b1, 19'h7FFFF, 32'h0, 32'h0);
    apply(2'b01, 1'b1, 1'b1, 19'h3FFFF, 32'h0, 32'h0);
    // random phase
    for (int k = 0; k < 2000; k++)
      apply(2'($urandom), 1'($urandom), 1'($urandom), 19'($urandom),
            $urandom, $urandom);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule